// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Arbiter

This block sits between the interrupt flags of an 8-bit controller's peripherals and its CPU core. It watches five sources: external line 0, timer 0 overflow, external line 1, timer 1 overflow and the serial port. It decides which enabled source should interrupt the CPU next. When one is chosen, it raises a single request line and presents the 16-bit entry address for that source.

Software programs two 8-bit registers through a small write port. The first is an enable register: one bit per source plus a global master bit. The second is a level register that marks each source as high or low priority. Any pending high-level source wins over every low-level one. Within a level, a fixed order breaks ties.

The CPU pulses an acknowledge strobe when it takes the interrupt, and a return strobe when the handler finishes. From these the block tracks which levels are in service. While a low-level handler runs, only a high-level source may preempt it. While a high-level handler runs, nothing can.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the enable register, the level register and both in-service levels are clear, so `irqReq` is 0 whatever the flags are.
- R2: Source i is pending only when its flag is set, its enable bit i is 1 and enable bit 7 (global) is 1. The source bits are: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial. `irqReq` is 1 exactly when an eligible pending source exists.
- R3: While `irqReq` is 1, `irqVector` is 0x0003 + 8 × i for winning source i: 0x0003, 0x000B, 0x0013, 0x001B, 0x0023. While `irqReq` is 0, `irqVector` is 0x0000.
- R4: The serial source is flagged when either its receive flag or its transmit flag is set, or both.
- R5: Level-register bit i set to 1 makes source i high level. Any pending high-level source is chosen over all low-level ones.
- R6: Among pending sources of the same level, the lower bit index wins: external 0, then timer 0, then external 1, then timer 1, then serial.
- R7: `ackStrobe` while `irqReq` is 1 marks the winner's level as in service from the next cycle. While a low level is in service, only high-level sources can request. While a high level is in service, `irqReq` stays 0.
- R8: `retStrobe` clears the high in-service level if it is set, and otherwise the low one. When `retStrobe` and `ackStrobe` arrive in the same cycle, the acknowledge is ignored.
- R9: A pulse on `regWrEn` writes `regWrData` to the enable register when `regSel` is 0, and to the level register when `regSel` is 1. Bits 5 to 7 of the level register have no effect, and neither do bits 5 and 6 of the enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| srcFlags | input | 4 | Flags of external 0, timer 0, external 1, timer 1 (bits 0 to 3) |
| serRxFlag | input | 1 | Serial receive flag |
| serTxFlag | input | 1 | Serial transmit flag |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the enable register, 1 selects the level register |
| regWrData | input | 8 | Register write data |
| ackStrobe | input | 1 | CPU has taken the presented interrupt |
| retStrobe | input | 1 | CPU has finished the current handler |
| irqReq | output | 1 | Interrupt request to the CPU |
| irqVector | output | 16 | Entry address of the winning source |

## Verification
The assertions assume that the acknowledge and return strobes are single-cycle pulses, synchronous to `clk`. They also assume that the source flags stay steady across the cycle in which an acknowledge is sampled, so the captured level belongs to the source that was shown. The stimulus drives every input on the falling edge and holds the flags unchanged through each strobe pulse. It sweeps all flag patterns against all level settings and all enable values, and it sequences the strobes so that every in-service combination is reached and left again.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;

  // strobes from the control decoder to the datapath
  typedef struct packed {
    logic wrEnable;
    logic wrPrio;
    logic enterHigh;
    logic enterLow;
    logic leaveHigh;
    logic leaveLow;
  } ctrlStrobes_t;

endpackage

// File: rtl/vec_irq_pick.sv
module vec_irq_pick #(
  parameter int N = 5,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);

  // lowest set index wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/vec_irq_ctrl_seq.sv
module vec_irq_ctrl_seq
  import vec_irq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         regWrEn,
  input  logic         regSel,
  input  logic         ackStrobe,
  input  logic         retStrobe,
  input  logic         irqReq,
  input  logic         winIsHigh,
  input  logic         svcHigh,
  input  logic         svcLow,
  output ctrlStrobes_t strobes
);

  logic takeAck;

  assign takeAck = ackStrobe & ~retStrobe & irqReq;

  always_comb begin
    strobes.wrEnable  = regWrEn & ~regSel;
    strobes.wrPrio    = regWrEn & regSel;
    strobes.enterHigh = takeAck & winIsHigh;
    strobes.enterLow  = takeAck & ~winIsHigh;
    strobes.leaveHigh = retStrobe & svcHigh;
    strobes.leaveLow  = retStrobe & ~svcHigh & svcLow;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.enterHigh, strobes.enterLow, strobes.leaveHigh, strobes.leaveLow})); // R8

  AST_RET_BLOCKS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    retStrobe |-> !(strobes.enterHigh || strobes.enterLow)); // R8

endmodule

// File: rtl/vec_irq_datapath.sv
module vec_irq_datapath
  import vec_irq_pkg::*;
#(
  parameter int NUM_SRC    = 5,
  parameter int DATA_W     = 8,
  parameter int GLOBAL_BIT = 7,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [DATA_W-1:0]  wrData,
  input  ctrlStrobes_t       strobes,
  output logic               irqReq,
  output logic [VEC_W-1:0]   irqVector,
  output logic               winIsHigh,
  output logic               svcHigh,
  output logic               svcLow
);

  localparam logic [VEC_W-1:0] BASE_V   = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0] STRIDE_V = VEC_W'(VEC_STRIDE);
  localparam logic [VEC_W-1:0] TOP_V    = VEC_W'(VEC_BASE + (NUM_SRC - 1) * VEC_STRIDE);

  logic [NUM_SRC-1:0] enSrc;
  logic               enGlobal;
  logic [NUM_SRC-1:0] prioQ;
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] hiPend;
  logic [NUM_SRC-1:0] loPend;
  logic               hiHit;
  logic               loHit;
  logic [IDX_W-1:0]   hiIdx;
  logic [IDX_W-1:0]   loIdx;
  logic [IDX_W-1:0]   winIdx;
  logic               useHigh;
  logic               useLow;
  logic               unusedWr;

  assign unusedWr = &{1'b0, wrData[GLOBAL_BIT-1:NUM_SRC]};

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enSrc    <= '0;
      enGlobal <= 1'b0;
      prioQ    <= '0;
    end else begin
      if (strobes.wrEnable) begin
        enSrc    <= wrData[NUM_SRC-1:0];
        enGlobal <= wrData[GLOBAL_BIT];
      end
      if (strobes.wrPrio) prioQ <= wrData[NUM_SRC-1:0];
    end
  end

  // in-service levels
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      svcHigh <= 1'b0;
      svcLow  <= 1'b0;
    end else begin
      if (strobes.leaveHigh)      svcHigh <= 1'b0;
      else if (strobes.enterHigh) svcHigh <= 1'b1;
      if (strobes.leaveLow)       svcLow  <= 1'b0;
      else if (strobes.enterLow)  svcLow  <= 1'b1;
    end
  end

  assign pending = srcReq & enSrc & {NUM_SRC{enGlobal}};
  assign hiPend  = pending & prioQ;
  assign loPend  = pending & ~prioQ;

  // one finder per level
  for (genvar lv = 0; lv < 2; lv++) begin : g_level
    if (lv == 0) begin : g_hi
      vec_irq_pick #(.N(NUM_SRC)) u_pick (.req(hiPend), .hit(hiHit), .idx(hiIdx));
    end else begin : g_lo
      vec_irq_pick #(.N(NUM_SRC)) u_pick (.req(loPend), .hit(loHit), .idx(loIdx));
    end
  end

  assign useHigh   = hiHit & ~svcHigh;
  assign useLow    = ~useHigh & loHit & ~svcHigh & ~svcLow;
  assign irqReq    = useHigh | useLow;
  assign winIsHigh = useHigh;
  assign winIdx    = useHigh ? hiIdx : loIdx;
  assign irqVector = irqReq ? (BASE_V + VEC_W'(winIdx) * STRIDE_V) : '0;

  AST_HIGH_SILENCES: assert property (@(posedge clk) disable iff (!rstN)
    svcHigh |-> !irqReq); // R7

  AST_LOW_ONLY_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (svcLow && irqReq) |-> winIsHigh); // R7

  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rstN)
    !enGlobal |-> !irqReq); // R2

  AST_WIN_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (srcReq[winIdx] && enSrc[winIdx])); // R2

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (irqVector >= BASE_V && irqVector <= TOP_V)); // R3

  AST_ENTER_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enterHigh |=> svcHigh); // R7

  AST_RET_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    strobes.leaveHigh |=> !svcHigh); // R8

  AST_RET_LOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.leaveLow |=> (!svcLow && $stable(svcHigh))); // R8

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int NUM_SRC    = 5,
  parameter int DATA_W     = 8,
  parameter int GLOBAL_BIT = 7,
  parameter int VEC_W      = 16,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8,
  localparam int NUM_DEV = NUM_SRC - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DEV-1:0] srcFlags,
  input  logic               serRxFlag,
  input  logic               serTxFlag,
  input  logic               regWrEn,
  input  logic               regSel,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic               ackStrobe,
  input  logic               retStrobe,
  output logic               irqReq,
  output logic [VEC_W-1:0]   irqVector
);

  ctrlStrobes_t       strobes;
  logic [NUM_SRC-1:0] srcReq;
  logic               winIsHigh;
  logic               svcHigh;
  logic               svcLow;

  assign srcReq = {serRxFlag | serTxFlag, srcFlags};

  vec_irq_ctrl_seq u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .ackStrobe(ackStrobe), .retStrobe(retStrobe), .irqReq(irqReq),
    .winIsHigh(winIsHigh), .svcHigh(svcHigh), .svcLow(svcLow),
    .strobes(strobes)
  );

  vec_irq_datapath #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .GLOBAL_BIT(GLOBAL_BIT),
    .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_path (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .wrData(regWrData),
    .strobes(strobes), .irqReq(irqReq), .irqVector(irqVector),
    .winIsHigh(winIsHigh), .svcHigh(svcHigh), .svcLow(svcLow)
  );

endmodule

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  srcFlags = '0;
  logic        serRxFlag = 1'b0;
  logic        serTxFlag = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [7:0]  regWrData = '0;
  logic        ackStrobe = 1'b0;
  logic        retStrobe = 1'b0;
  logic        irqReq;
  logic [15:0] irqVector;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  vec_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .srcFlags(srcFlags), .serRxFlag(serRxFlag),
    .serTxFlag(serTxFlag), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .ackStrobe(ackStrobe), .retStrobe(retStrobe),
    .irqReq(irqReq), .irqVector(irqVector)
  );

  // reference: {req, vector} from flags, enable, level and in-service state
  function automatic logic [16:0] model(input logic [4:0] f, input logic [7:0] en,
                                        input logic [7:0] pr, input bit sh, input bit sl);
    logic [4:0] p;
    p = f & en[4:0] & {5{en[7]}};
    if (!sh)
      for (int i = 0; i < 5; i++)
        if (p[i] && pr[i]) return {1'b1, 16'(3 + 8 * i)};
    if (!sh && !sl)
      for (int i = 0; i < 5; i++)
        if (p[i] && !pr[i]) return {1'b1, 16'(3 + 8 * i)};
    return 17'd0;
  endfunction

  task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: req/vector actual %0b/%h expected %0b/%h",
               tag, act[16], act[15:0], exp[16], exp[15:0]);
    end
  endtask

  task automatic writeReg(input bit sel, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic setFlags(input logic [4:0] f);
    @(negedge clk);
    srcFlags = f[3:0]; serRxFlag = f[4]; serTxFlag = 1'b0;
    #5;
  endtask

  task automatic pulse(input bit ack, input bit ret);
    @(negedge clk);
    ackStrobe = ack; retStrobe = ret;
    @(negedge clk);
    ackStrobe = 1'b0; retStrobe = 1'b0;
    #5;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end

  initial begin
    // R1: reset state
    srcFlags = 4'hF; serRxFlag = 1'b1;
    #35;
    check("R1 in reset", {irqReq, irqVector}, 17'd0);
    rstN = 1'b1;
    @(negedge clk); #5;
    check("R1 after reset", {irqReq, irqVector}, 17'd0);

    // R5 R6 R3: every level setting against every flag pattern
    writeReg(1'b0, 8'h9F);
    for (int p = 0; p < 32; p++) begin
      writeReg(1'b1, 8'(p));
      for (int f = 0; f < 32; f++) begin
        setFlags(5'(f));
        check("R5/R6/R3 level sweep", {irqReq, irqVector}, model(5'(f), 8'h9F, 8'(p), 0, 0));
      end
    end

    // R2 R9: every enable value with all flags up
    writeReg(1'b1, 8'h00);
    setFlags(5'h1F);
    for (int e = 0; e < 256; e++) begin
      writeReg(1'b0, 8'(e));
      #5;
      check("R2/R9 enable sweep", {irqReq, irqVector}, model(5'h1F, 8'(e), 8'h00, 0, 0));
    end

    // R9: level bits 5-7 ignored
    writeReg(1'b0, 8'h9F);
    writeReg(1'b1, 8'hE0);
    setFlags(5'h12);
    check("R9 upper level bits", {irqReq, irqVector}, {1'b1, 16'h000B});

    // R4: serial from either flag
    writeReg(1'b0, 8'h90);
    @(negedge clk); srcFlags = 4'h0; serRxFlag = 1'b0; serTxFlag = 1'b1; #5;
    check("R4 tx only", {irqReq, irqVector}, {1'b1, 16'h0023});
    @(negedge clk); serRxFlag = 1'b1; serTxFlag = 1'b1; #5;
    check("R4 both", {irqReq, irqVector}, {1'b1, 16'h0023});
    @(negedge clk); serRxFlag = 1'b0; serTxFlag = 1'b0; #5;
    check("R4 none", {irqReq, irqVector}, 17'd0);

    // R7 R8: nesting, timer 1 high, rest low
    writeReg(1'b0, 8'h9F);
    writeReg(1'b1, 8'h08);
    setFlags(5'h01);
    check("R7 low request", {irqReq, irqVector}, {1'b1, 16'h0003});
    pulse(1'b1, 1'b0);
    check("R7 low in service blocks low", {irqReq, irqVector}, 17'd0);
    setFlags(5'h09);
    check("R7 high preempts low", {irqReq, irqVector}, {1'b1, 16'h001B});
    pulse(1'b1, 1'b0);
    setFlags(5'h1F);
    check("R7 high in service blocks all", {irqReq, irqVector}, 17'd0);
    pulse(1'b0, 1'b1);
    check("R8 return clears high first", {irqReq, irqVector}, {1'b1, 16'h001B});
    setFlags(5'h01);
    check("R8 low still in service", {irqReq, irqVector}, 17'd0);
    pulse(1'b0, 1'b1);
    check("R8 return clears low", {irqReq, irqVector}, {1'b1, 16'h0003});

    // R8: return beside acknowledge drops the acknowledge
    pulse(1'b1, 1'b1);
    check("R8 ack ignored with return", {irqReq, irqVector}, {1'b1, 16'h0003});
    // R7: high entered directly from idle
    setFlags(5'h08);
    pulse(1'b1, 1'b0);
    setFlags(5'h01);
    check("R7 high from idle blocks low", {irqReq, irqVector}, 17'd0);
    pulse(1'b0, 1'b1);
    check("R8 idle after single return", {irqReq, irqVector}, {1'b1, 16'h0003});

    finished = 1'b1;
    summary();
  end

endmodule